// File: doc/BRIEF.md
# Hot-Swap Start-Up Sequencer

This block is the digital control core of a controller that lets a card be plugged into a powered negative-rail backplane. It reads four comparator flags and produces the controls for the external pass transistor. The flags report that the internal supply is healthy, that the input rail is above its undervoltage limit (with a separate higher flag for the limit plus hysteresis), that the gate voltage has reached the adapt reference, and that the gate is rising in step with the reference ramp. The outputs are a gate enable, a one-cycle strobe that freezes the adapted pull-up current, a reference-ramp enable, a fault flag, a power-good flag and a one-hot copy of the state.

Start-up runs in a fixed order. First comes a debounce wait that starts over on every input glitch. Next is an adapt phase that ends when the drive current is frozen. Then a ramp phase watches for the gate plateau that appears while the load capacitance charges. If the gate keeps tracking the ramp with no plateau, the load is taken to be shorted. The gate is then switched off and a long back-off runs before a fresh debounce. A low input or supply drops the gate in the same cycle and sends the block back to its idle state. All timer lengths are parameters given in clock cycles.

Top module: `hotswap_seq`

## Requirements
- R1: While `supply_ok` is low, `gate_en`, `ramp_en`, `hold_strobe` and `power_good` are low in that same cycle, and the state is RESET after the next clock edge.
- R2: The block leaves RESET for POR_WAIT only on an edge where `supply_ok`, `in_ok` and `in_hi` are all high.
- R3: POR_WAIT lasts exactly POR_CYCLES clock cycles before ADAPT is entered. If `in_ok` drops during POR_WAIT, the block returns to RESET, and the next attempt waits a full POR_CYCLES again.
- R4: In ADAPT, `gate_en` and `ramp_en` are high and `hold_strobe` stays low until `gate_above_ref` is seen.
- R5: In ADAPT, `hold_strobe` is high in the cycle where `gate_above_ref` is high. The next state is RAMP, so the strobe lasts exactly one cycle.
- R6: In RAMP, a cycle with `gate_tracking` low marks the plateau. A later cycle with `gate_tracking` high moves the block to FULL_ON, where `gate_en` and `power_good` are high and `ramp_en` is low.
- R7: If `gate_tracking` is high in every one of the first SHORT_CYCLES cycles of RAMP, the block enters FAULT_WAIT. There `gate_en` is low and `fault` is high.
- R8: `fault` stays high for exactly RETRY_CYCLES cycles. The block then enters POR_WAIT and runs a full debounce again.
- R9: While `in_ok` is low, `gate_en`, `ramp_en`, `hold_strobe` and `power_good` are low in that same cycle. The next state is RESET from any state, including FAULT_WAIT, which also clears `fault`.
- R10: `state_onehot` has exactly one bit set. The bits are: bit 0 RESET, bit 1 POR_WAIT, bit 2 ADAPT, bit 3 RAMP, bit 4 FULL_ON, bit 5 FAULT_WAIT.
- R11: While `rst_n` is low, the state is RESET and every output other than `state_onehot` is low.
- R12: Outside ADAPT, `gate_above_ref` has no effect: `hold_strobe` stays low in RAMP and FULL_ON.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Internal supply above its lockout level |
| in_ok | input | 1 | Input rail above the undervoltage limit |
| in_hi | input | 1 | Input rail above the limit plus hysteresis |
| gate_above_ref | input | 1 | Gate voltage has reached the adapt reference |
| gate_tracking | input | 1 | Gate rises at the reference ramp rate |
| gate_en | output | 1 | Enables the gate pull-up |
| hold_strobe | output | 1 | One-cycle pulse that samples and holds the drive current |
| ramp_en | output | 1 | Enables the reference ramp generator |
| fault | output | 1 | Short-circuit back-off in progress |
| power_good | output | 1 | Transistor fully on |
| state_onehot | output | 6 | One-hot state, encoded as in R10 |

## Verification
The bench places a single-cycle input glitch part-way through the debounce. A design that kept counting instead of restarting would turn the gate on about ten cycles early. It counts the cycles from fault entry to restart: an off-by-one in the back-off timer changes that count, and a restart into ADAPT instead of POR_WAIT skips the second debounce. A ramp that tracks for the whole window separates short detection from a plateau that arrives late, and a design that wrongly declared a short would show up as a missing power-good. An undervoltage during the back-off catches a design that lets the fault flag outlive a reset.

// File: rtl/hotswap_pkg.sv
package hotswap_pkg;

  typedef enum logic [2:0] {
    ST_RESET = 3'd0,
    ST_POR   = 3'd1,
    ST_ADAPT = 3'd2,
    ST_RAMP  = 3'd3,
    ST_ON    = 3'd4,
    ST_FAULT = 3'd5
  } hs_state_e;

  localparam int unsigned NUM_STATES = 6;

  // Bits needed to count 0 .. n-1.
  function automatic int unsigned cnt_width(int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [NUM_STATES-1:0] state_to_onehot(hs_state_e s);
    logic [NUM_STATES-1:0] v;
    v = '0;
    v[s] = 1'b1;
    return v;
  endfunction

  // States in which the gate pull-up is allowed to run.
  function automatic logic drives_gate(hs_state_e s);
    return (s == ST_ADAPT) || (s == ST_RAMP) || (s == ST_ON);
  endfunction

  // States in which the reference ramp is needed.
  function automatic logic needs_ramp(hs_state_e s);
    return (s == ST_ADAPT) || (s == ST_RAMP);
  endfunction

endpackage

// File: rtl/hs_timer.sv
module hs_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [TW-1:0] limit_m1,
  output logic          expired
);

  logic [TW-1:0] cnt_q;

  assign expired = run && (cnt_q == limit_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr)        cnt_q <= '0;
    else if (run)        cnt_q <= cnt_q + 1'b1;
  end

  // R3 / R8: the shared timer never runs past the limit of the timed state.
  a_r3_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= limit_m1));

endmodule

// File: rtl/hs_short_det.sv
module hs_short_det #(
  parameter int unsigned SHORT_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tracking,
  output logic short_fault,
  output logic rise_resumed
);
  import hotswap_pkg::*;

  localparam int unsigned SW = cnt_width(SHORT_CYCLES);
  localparam logic [SW-1:0] WIN_LAST = SW'(SHORT_CYCLES - 1);

  logic [SW-1:0] win_q;
  logic          plateau_q;

  assign short_fault  = en && !plateau_q && tracking && (win_q == WIN_LAST);
  assign rise_resumed = en && plateau_q && tracking;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q     <= '0;
      plateau_q <= 1'b0;
    end else if (!en) begin
      win_q     <= '0;
      plateau_q <= 1'b0;
    end else if (!plateau_q) begin
      if (!tracking)         plateau_q <= 1'b1;
      else if (!short_fault) win_q     <= win_q + 1'b1;
    end
  end

  // R7: the window counter stays inside the short-detection window.
  a_r7_window_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (win_q <= WIN_LAST));

  // R6: once a plateau has been seen, the window stops advancing.
  a_r6_window_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (en && plateau_q) |=> (!en || $stable(win_q)));

endmodule

// File: rtl/hs_fsm.sv
module hs_fsm (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  live,
  input  logic                  in_hi,
  input  logic                  gate_above_ref,
  input  logic                  tmr_expired,
  input  logic                  short_fault,
  input  logic                  rise_resumed,
  output hotswap_pkg::hs_state_e state_q,
  output logic                  adapt_hold,
  output logic                  tmr_run,
  output logic                  tmr_retry,
  output logic                  tmr_clr
);
  import hotswap_pkg::*;

  hs_state_e state_d;

  assign adapt_hold = live && (state_q == ST_ADAPT) && gate_above_ref;
  assign tmr_run    = (state_q == ST_POR) || (state_q == ST_FAULT);
  assign tmr_retry  = (state_q == ST_FAULT);
  assign tmr_clr    = (state_d != state_q);

  always_comb begin
    state_d = state_q;
    if (!live) begin
      state_d = ST_RESET;
    end else begin
      case (state_q)
        ST_RESET: if (in_hi)        state_d = ST_POR;
        ST_POR:   if (tmr_expired)  state_d = ST_ADAPT;
        ST_ADAPT: if (adapt_hold)   state_d = ST_RAMP;
        ST_RAMP: begin
          if (short_fault)          state_d = ST_FAULT;
          else if (rise_resumed)    state_d = ST_ON;
        end
        ST_ON:                      state_d = ST_ON;
        ST_FAULT: if (tmr_expired)  state_d = ST_POR;
        default:                    state_d = ST_RESET;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RESET;
    else        state_q <= state_d;
  end

  // R2: leaving RESET needs the hysteresis flag.
  a_r2_start_needs_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESET && !in_hi) |=> (state_q == ST_RESET));

  // R3: ADAPT is reached only from a debounce whose timer ran out.
  a_r3_adapt_after_por: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POR && !tmr_expired) |=> (state_q != ST_ADAPT));

endmodule

// File: rtl/hotswap_seq.sv
module hotswap_seq #(
  parameter int unsigned POR_CYCLES   = 350000,
  parameter int unsigned RETRY_CYCLES = 250000000,
  parameter int unsigned SHORT_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok,
  input  logic       in_ok,
  input  logic       in_hi,
  input  logic       gate_above_ref,
  input  logic       gate_tracking,
  output logic       gate_en,
  output logic       hold_strobe,
  output logic       ramp_en,
  output logic       fault,
  output logic       power_good,
  output logic [5:0] state_onehot
);
  import hotswap_pkg::*;

  localparam int unsigned TW = cnt_width(max_u(POR_CYCLES, RETRY_CYCLES));
  localparam logic [TW-1:0] POR_LAST   = TW'(POR_CYCLES - 1);
  localparam logic [TW-1:0] RETRY_LAST = TW'(RETRY_CYCLES - 1);

  hs_state_e     state_q;
  logic          live;
  logic          adapt_hold;
  logic          tmr_run, tmr_retry, tmr_clr, tmr_expired;
  logic          short_fault, rise_resumed;
  logic [TW-1:0] limit_m1;

  assign live     = supply_ok && in_ok;
  assign limit_m1 = tmr_retry ? RETRY_LAST : POR_LAST;

  hs_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .live           (live),
    .in_hi          (in_hi),
    .gate_above_ref (gate_above_ref),
    .tmr_expired    (tmr_expired),
    .short_fault    (short_fault),
    .rise_resumed   (rise_resumed),
    .state_q        (state_q),
    .adapt_hold     (adapt_hold),
    .tmr_run        (tmr_run),
    .tmr_retry      (tmr_retry),
    .tmr_clr        (tmr_clr)
  );

  hs_timer #(.TW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (tmr_clr),
    .run      (tmr_run),
    .limit_m1 (limit_m1),
    .expired  (tmr_expired)
  );

  hs_short_det #(.SHORT_CYCLES(SHORT_CYCLES)) u_short (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (state_q == ST_RAMP),
    .tracking     (gate_tracking),
    .short_fault  (short_fault),
    .rise_resumed (rise_resumed)
  );

  assign gate_en      = live && drives_gate(state_q);
  assign ramp_en      = live && needs_ramp(state_q);
  assign hold_strobe  = adapt_hold;
  assign power_good   = live && (state_q == ST_ON);
  assign fault        = (state_q == ST_FAULT);
  assign state_onehot = state_to_onehot(state_q);

  // R1: a supply drop returns the sequencer to RESET.
  a_r1_supply_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> (state_q == ST_RESET));

  // R9: an input undervoltage returns the sequencer to RESET.
  a_r9_uv_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ok |=> (state_q == ST_RESET && !fault));

  // R5: the hold strobe never lasts more than one cycle.
  a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    hold_strobe |=> !hold_strobe);

  // R7: the back-off starts only from a detected short.
  a_r7_fault_from_short: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> $past(short_fault));

  // R8: a back-off that ends with the input healthy goes to the debounce.
  a_r8_retry_to_por: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(fault) && $past(live)) |-> (state_q == ST_POR));

  // R10: exactly one state bit is set.
  a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(state_onehot) == 1);

  // R6: power good is only seen with the gate driven.
  a_r6_pgood_gate: assert property (@(posedge clk) disable iff (!rst_n)
    power_good |-> (gate_en && !ramp_en));

endmodule

// File: tb/hotswap_seq_tb.sv
module hotswap_seq_tb_top;

  localparam int CLK_P  = 10;
  localparam int POR_N  = 20;
  localparam int RTRY_N = 50;
  localparam int SHRT_N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic supply_ok = 1'b0, in_ok = 1'b0, in_hi = 1'b0;
  logic gate_above_ref = 1'b0, gate_tracking = 1'b0;
  logic gate_en, hold_strobe, ramp_en, fault, power_good;
  logic [5:0] state_onehot;

  int n_tests = 0;
  int n_fail  = 0;
  string tag = "R11";
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  hotswap_seq #(.POR_CYCLES(POR_N), .RETRY_CYCLES(RTRY_N), .SHORT_CYCLES(SHRT_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .in_ok(in_ok), .in_hi(in_hi),
    .gate_above_ref(gate_above_ref), .gate_tracking(gate_tracking),
    .gate_en(gate_en), .hold_strobe(hold_strobe), .ramp_en(ramp_en), .fault(fault),
    .power_good(power_good), .state_onehot(state_onehot)
  );

  // Reference model: 0 idle, 1 debounce, 2 adapt, 3 ramp, 4 on, 5 back-off.
  int m_st = 0, m_cnt = 0, m_win = 0;
  bit m_plat = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_cnt <= 0; m_win <= 0; m_plat <= 0;
    end else if (!(supply_ok && in_ok)) begin
      m_st <= 0; m_cnt <= 0; m_win <= 0; m_plat <= 0;
    end else begin
      case (m_st)
        0: if (in_hi) begin m_st <= 1; m_cnt <= 0; end
        1: if (m_cnt == POR_N - 1) m_st <= 2; else m_cnt <= m_cnt + 1;
        2: if (gate_above_ref) begin m_st <= 3; m_win <= 0; m_plat <= 0; end
        3: begin
          if (m_plat) begin
            if (gate_tracking) m_st <= 4;
          end else if (!gate_tracking) m_plat <= 1;
          else if (m_win + 1 == SHRT_N) begin m_st <= 5; m_cnt <= 0; end
          else m_win <= m_win + 1;
        end
        5: if (m_cnt == RTRY_N - 1) begin m_st <= 1; m_cnt <= 0; end
           else m_cnt <= m_cnt + 1;
        default: ;
      endcase
    end
  end

  // Scoreboard: expected items pushed by the model side, popped by the monitor.
  logic [10:0] exp_q[$];
  string       tag_q[$];

  always @(negedge clk) begin
    bit lv;
    #3;
    lv = supply_ok && in_ok;
    exp_q.push_back({lv && (m_st == 2 || m_st == 3 || m_st == 4),
                     lv && m_st == 2 && gate_above_ref,
                     lv && (m_st == 2 || m_st == 3),
                     m_st == 5,
                     lv && m_st == 4,
                     6'(1 << m_st)});
    tag_q.push_back(tag);
  end

  always @(negedge clk) begin
    logic [10:0] e, a;
    string t;
    #4;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {gate_en, hold_strobe, ramp_en, fault, power_good, state_onehot};
      n_tests++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s cycle compare: actual %b expected %b", t, a, e);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string t, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic wait_adapt();
    int guard = 0;
    while (!state_onehot[2] && guard < 1000) begin tick(1); guard++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int n;
    // R11: reset holds idle state
    tag = "R11";
    tick(3); #1;
    chk(gate_en == 0 && fault == 0 && power_good == 0, "R11", gate_en, 0);
    chk(state_onehot == 6'b000001, "R10", state_onehot, 1);
    tick(1); rst_n = 1'b1;

    // R1: no supply, healthy input
    tag = "R1";
    in_ok = 1; in_hi = 1;
    tick(4); #1;
    chk(gate_en == 0 && state_onehot[0], "R1", gate_en, 0);

    // R3: glitch part-way into the debounce
    tick(1); tag = "R3"; supply_ok = 1;
    tick(10); in_ok = 0; in_hi = 0;
    tick(1); in_ok = 1; in_hi = 1;
    n = 0;
    while (!state_onehot[2] && n < 200) begin tick(1); n++; end
    chk(n == POR_N + 1, "R3", n, POR_N + 1);

    // R4: adapting
    tag = "R4"; #1;
    chk(gate_en && ramp_en && !hold_strobe, "R4", {gate_en, ramp_en, hold_strobe}, 3'b110);
    tick(3);

    // R5: strobe on reference crossing
    tag = "R5"; gate_above_ref = 1; #1;
    chk(hold_strobe == 1, "R5", hold_strobe, 1);
    tick(1); #1;
    chk(hold_strobe == 0 && state_onehot[3], "R12", hold_strobe, 0);

    // R6: plateau then resumed rise
    tag = "R6"; gate_tracking = 1; tick(3);
    gate_tracking = 0; tick(4);
    gate_tracking = 1; tick(1); #1;
    chk(power_good && gate_en && !ramp_en, "R6", power_good, 1);
    tick(5);
    tag = "R12"; gate_above_ref = 0; tick(2); gate_above_ref = 1; #1;
    chk(hold_strobe == 0, "R12", hold_strobe, 0);
    tick(2);

    // R9: undervoltage in FULL_ON
    tag = "R9"; in_ok = 0; in_hi = 0; #1;
    chk(!gate_en && !power_good, "R9", gate_en, 0);
    tick(1); #1;
    chk(state_onehot == 6'b000001, "R9", state_onehot, 1);

    // R7: shorted load, tracking never stops
    tag = "R7"; gate_above_ref = 0; gate_tracking = 1; in_ok = 1; in_hi = 1;
    wait_adapt();
    gate_above_ref = 1; tick(1);
    n = 0;
    while (!fault && n < 100) begin tick(1); n++; end
    chk(n == SHRT_N, "R7", n, SHRT_N);
    #1; chk(gate_en == 0 && fault == 1, "R7", gate_en, 0);

    // R8: back-off length and restart through debounce
    tag = "R8"; gate_above_ref = 0;
    n = 0;
    while (fault && n < 500) begin tick(1); n++; end
    chk(n == RTRY_N, "R8", n, RTRY_N);
    #1; chk(state_onehot == 6'b000010, "R8", state_onehot, 2);

    // R9: undervoltage during the back-off
    wait_adapt();
    tag = "R9"; gate_above_ref = 1; tick(1);
    while (!fault && n < 1000) begin tick(1); n++; end
    tick(5); in_ok = 0; in_hi = 0; tick(1); #1;
    chk(fault == 0 && state_onehot[0], "R9", fault, 0);

    // R1: supply drop while adapting
    tag = "R2"; gate_above_ref = 0; in_ok = 1; tick(3); #1;
    chk(state_onehot[0], "R2", state_onehot, 1);
    in_hi = 1; wait_adapt();
    tag = "R1"; supply_ok = 0; #1;
    chk(!gate_en && !ramp_en, "R1", gate_en, 0);
    tick(1); #1;
    chk(state_onehot == 6'b000001, "R1", state_onehot, 1);
    tick(3);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule